// File: doc/BRIEF.md
# UART Line Status Flags

This block holds the line status byte of a classic single-buffered UART. The receiver sends it one-cycle event pulses: a word has been moved into the receive buffer, the word had a parity error, the word had a bad stop bit, or a break was seen on the serial input. The transmitter sends it two levels that say whether its holding register and its shift register are empty. The host bus interface sends it read strobes for the status register, the receive buffer and the interrupt-ID register, and a write strobe for the transmit holding register.

The block keeps a sticky flag for each condition. Each flag has its own set and clear rules. From the flags it builds the readable status byte and three interrupt requests: receive data available, line status and transmitter holding empty. Each request is gated by its own enable input. Interrupt priority encoding, baud generation and serial shifting sit in neighbouring blocks.

All flags are registered. An event sampled at a rising clock edge is visible on the outputs after that edge. When a set event and a clearing strobe arrive in the same cycle, the set wins.

Top module: `uart_line_status`

## Requirements
- R1: After reset `lineStatus` reads 8'h60: bits 5 and 6 are set and all other bits are clear.
- R2: Bit 0 (data ready) sets on the edge where `rxWordLoad` is high. It clears on the edge where `rdRxBuf` is high and `rxWordLoad` is low.
- R3: Bit 1 (overrun) sets on an edge where `rxWordLoad` is high while bit 0 is already set and `rdRxBuf` is low. It clears on an edge where `rdLineStat` is high and no overrun is being set.
- R4: Bit 2 (parity error) sets on an edge where `rxParityErr` is high. Bit 3 (framing error) sets on an edge where `rxFrameErr` is high. Each clears on an edge where `rdLineStat` is high and its own set pulse is low.
- R5: Bit 4 (break) sets on an edge where `rxBreak` is high. The receiver raises that pulse when the serial input has stayed low for longer than one full word time. The bit clears on an edge where `rdLineStat` is high and `rxBreak` is low.
- R6: Bit 5 (holding empty) sets on an edge where `txHoldEmpty` is high after having been low at the previous edge. It clears on an edge where `rdIntId` or `wrTxHold` is high and no such rise occurs.
- R7: Bit 6 (transmitter empty) equals `txHoldEmpty && txShiftEmpty` as sampled at the previous edge.
- R8: Bit 7 always reads 0.
- R9: `irqRxData` equals bit 0 AND `enRxDataIrq`.
- R10: `irqLineStat` equals (OR of bits 1 to 4) AND `enLineStatIrq`.
- R11: `irqTxEmpty` equals bit 5 AND `enTxEmptyIrq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxWordLoad | input | 1 | Pulse: received word written into the receive buffer |
| rxParityErr | input | 1 | Pulse: the received word had bad parity |
| rxFrameErr | input | 1 | Pulse: the received word had a bad stop bit |
| rxBreak | input | 1 | Pulse: break condition detected on the serial input |
| txHoldEmpty | input | 1 | Level: transmit holding register empty |
| txShiftEmpty | input | 1 | Level: transmit shift register empty |
| rdLineStat | input | 1 | Host read of the line status register |
| rdRxBuf | input | 1 | Host read of the receive buffer register |
| rdIntId | input | 1 | Host read of the interrupt-ID register |
| wrTxHold | input | 1 | Host write of the transmit holding register |
| enRxDataIrq | input | 1 | Enable for the receive-data-available request |
| enLineStatIrq | input | 1 | Enable for the line status request |
| enTxEmptyIrq | input | 1 | Enable for the holding-empty request |
| lineStatus | output | 8 | Readable status byte |
| irqRxData | output | 1 | Receive data available request |
| irqLineStat | output | 1 | Line status request |
| irqTxEmpty | output | 1 | Holding register empty request |

## Verification
The bench builds the block with its default parameter, which lets a receive-buffer read issued in the same cycle as a new word prevent an overrun. That setting puts the three-way overlap of load, buffer read and status read within reach, along with the rule that the set wins. Directed sequences first cover each flag's set, clear and same-cycle collision. A long randomized phase then overlaps all strobes, toggles the transmitter levels and flips the enables. This exercises rising-edge detection on the holding-empty level and the gating of every request.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  localparam int STATUS_W   = 8;
  localparam int ERR_CNT    = 4;

  // Bit positions of the status byte; the host driver decodes these.
  localparam int BIT_DR     = 0;
  localparam int BIT_ERR_LO = 1;
  localparam int BIT_THRE   = 5;
  localparam int BIT_TEMT   = 6;
  localparam int BIT_SPARE  = 7;

  // Order of the error vector: overrun, parity, framing, break.
  localparam int ERR_OE = 0;
  localparam int ERR_PE = 1;
  localparam int ERR_FE = 2;
  localparam int ERR_BI = 3;

  typedef struct packed {
    logic               setDr;
    logic               clrDr;
    logic [ERR_CNT-1:0] errSet;
    logic               clrErr;
    logic               setThre;
    logic               clrThre;
    logic               temtNext;
  } lsrStrobe_t;

endpackage

// File: rtl/lsr_control.sv
module lsr_control
  import lsr_pkg::*;
#(
  parameter bit RBR_READ_RESCUES = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxWordLoad,
  input  logic       rxParityErr,
  input  logic       rxFrameErr,
  input  logic       rxBreak,
  input  logic       txHoldEmpty,
  input  logic       txShiftEmpty,
  input  logic       rdLineStat,
  input  logic       rdRxBuf,
  input  logic       rdIntId,
  input  logic       wrTxHold,
  input  logic       drNow,
  output lsrStrobe_t strb
);

  logic holdPrev;
  logic holdRise;
  logic overrun;

  // Previous holding-empty level; reset matches the reset value of the flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdPrev <= 1'b1;
    else       holdPrev <= txHoldEmpty;
  end

  assign holdRise = txHoldEmpty && !holdPrev;

  generate
    if (RBR_READ_RESCUES) begin : g_rescue
      assign overrun = rxWordLoad && drNow && !rdRxBuf;
    end else begin : g_strict
      assign overrun = rxWordLoad && drNow;
    end
  endgenerate

  always_comb begin
    strb                = '0;
    strb.setDr          = rxWordLoad;
    strb.clrDr          = rdRxBuf;
    strb.errSet[ERR_OE] = overrun;
    strb.errSet[ERR_PE] = rxParityErr;
    strb.errSet[ERR_FE] = rxFrameErr;
    strb.errSet[ERR_BI] = rxBreak;
    strb.clrErr         = rdLineStat;
    strb.setThre        = holdRise;
    strb.clrThre        = rdIntId || wrTxHold;
    strb.temtNext       = txHoldEmpty && txShiftEmpty;
  end

  // R3: an overrun strobe never fires without a word load.
  p_ovr_needs_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.errSet[ERR_OE] |-> rxWordLoad);

  // R6: the holding-empty set strobe only on a low-to-high change.
  p_thre_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.setThre |=> !strb.setThre);

endmodule

// File: rtl/lsr_datapath.sv
module lsr_datapath
  import lsr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  lsrStrobe_t          strb,
  input  logic                enRxDataIrq,
  input  logic                enLineStatIrq,
  input  logic                enTxEmptyIrq,
  output logic                drNow,
  output logic [STATUS_W-1:0] lineStatus,
  output logic                irqRxData,
  output logic                irqLineStat,
  output logic                irqTxEmpty
);

  logic               drFlag;
  logic [ERR_CNT-1:0] errFlags;
  logic               threFlag;
  logic               temtFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           drFlag <= 1'b0;
    else if (strb.setDr) drFlag <= 1'b1;
    else if (strb.clrDr) drFlag <= 1'b0;
  end

  genvar g;
  generate
    for (g = 0; g < ERR_CNT; g++) begin : g_err
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                errFlags[g] <= 1'b0;
        else if (strb.errSet[g])  errFlags[g] <= 1'b1;
        else if (strb.clrErr)     errFlags[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             threFlag <= 1'b1;
    else if (strb.setThre) threFlag <= 1'b1;
    else if (strb.clrThre) threFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) temtFlag <= 1'b1;
    else       temtFlag <= strb.temtNext;
  end

  always_comb begin
    lineStatus                                 = '0;
    lineStatus[BIT_DR]                         = drFlag;
    lineStatus[BIT_ERR_LO +: ERR_CNT]          = errFlags;
    lineStatus[BIT_THRE]                       = threFlag;
    lineStatus[BIT_TEMT]                       = temtFlag;
    lineStatus[BIT_SPARE]                      = 1'b0;
  end

  assign drNow       = drFlag;
  assign irqRxData   = drFlag && enRxDataIrq;
  assign irqLineStat = (|errFlags) && enLineStatIrq;
  assign irqTxEmpty  = threFlag && enTxEmptyIrq;

  // R2: a load strobe always leaves data ready set.
  p_dr_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDr |=> lineStatus[BIT_DR]);

  // R4: a status read with no parity pulse leaves the parity bit clear.
  p_pe_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrErr && !strb.errSet[ERR_PE]) |=> !lineStatus[BIT_ERR_LO + ERR_PE]);

  // R5: a break pulse wins over a same-cycle status read.
  p_bi_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.errSet[ERR_BI] |=> lineStatus[BIT_ERR_LO + ERR_BI]);

  // R6: a clearing access with no rise leaves holding-empty clear.
  p_thre_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrThre && !strb.setThre) |=> !lineStatus[BIT_THRE]);

endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import lsr_pkg::*;
#(
  parameter bit RBR_READ_RESCUES = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxWordLoad,
  input  logic                rxParityErr,
  input  logic                rxFrameErr,
  input  logic                rxBreak,
  input  logic                txHoldEmpty,
  input  logic                txShiftEmpty,
  input  logic                rdLineStat,
  input  logic                rdRxBuf,
  input  logic                rdIntId,
  input  logic                wrTxHold,
  input  logic                enRxDataIrq,
  input  logic                enLineStatIrq,
  input  logic                enTxEmptyIrq,
  output logic [STATUS_W-1:0] lineStatus,
  output logic                irqRxData,
  output logic                irqLineStat,
  output logic                irqTxEmpty
);

  lsrStrobe_t strb;
  logic       drNow;

  lsr_control #(
    .RBR_READ_RESCUES(RBR_READ_RESCUES)
  ) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .rxWordLoad  (rxWordLoad),
    .rxParityErr (rxParityErr),
    .rxFrameErr  (rxFrameErr),
    .rxBreak     (rxBreak),
    .txHoldEmpty (txHoldEmpty),
    .txShiftEmpty(txShiftEmpty),
    .rdLineStat  (rdLineStat),
    .rdRxBuf     (rdRxBuf),
    .rdIntId     (rdIntId),
    .wrTxHold    (wrTxHold),
    .drNow       (drNow),
    .strb        (strb)
  );

  lsr_datapath u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .enRxDataIrq  (enRxDataIrq),
    .enLineStatIrq(enLineStatIrq),
    .enTxEmptyIrq (enTxEmptyIrq),
    .drNow        (drNow),
    .lineStatus   (lineStatus),
    .irqRxData    (irqRxData),
    .irqLineStat  (irqLineStat),
    .irqTxEmpty   (irqTxEmpty)
  );

  // R7: transmitter-empty follows both transmit levels one edge later.
  p_temt_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txHoldEmpty && txShiftEmpty) |=> lineStatus[BIT_TEMT]);
  p_temt_clr_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(txHoldEmpty && txShiftEmpty) |=> !lineStatus[BIT_TEMT]);

  // R9: receive request never without data ready and its enable.
  p_rx_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqRxData |-> (lineStatus[BIT_DR] && enRxDataIrq));

  // R10: line status request never without its enable.
  p_ls_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqLineStat |-> enLineStatIrq);

  // R8: the spare bit stays low.
  p_spare_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !lineStatus[BIT_SPARE]);

endmodule

// File: tb/uart_line_status_tb.sv
module uart_line_status_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       rxWordLoad, rxParityErr, rxFrameErr, rxBreak;
  logic       txHoldEmpty, txShiftEmpty;
  logic       rdLineStat, rdRxBuf, rdIntId, wrTxHold;
  logic       enRxDataIrq, enLineStatIrq, enTxEmptyIrq;
  logic [7:0] lineStatus;
  logic       irqRxData, irqLineStat, irqTxEmpty;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // Behavioural reference state
  bit mDr, mOe, mPe, mFe, mBi, mThre, mTemt, mHoldPrev;

  always #10 clk = ~clk;

  uart_line_status u_dut (
    .clk(clk), .rstN(rstN),
    .rxWordLoad(rxWordLoad), .rxParityErr(rxParityErr),
    .rxFrameErr(rxFrameErr), .rxBreak(rxBreak),
    .txHoldEmpty(txHoldEmpty), .txShiftEmpty(txShiftEmpty),
    .rdLineStat(rdLineStat), .rdRxBuf(rdRxBuf),
    .rdIntId(rdIntId), .wrTxHold(wrTxHold),
    .enRxDataIrq(enRxDataIrq), .enLineStatIrq(enLineStatIrq),
    .enTxEmptyIrq(enTxEmptyIrq),
    .lineStatus(lineStatus), .irqRxData(irqRxData),
    .irqLineStat(irqLineStat), .irqTxEmpty(irqTxEmpty)
  );

  always @(posedge clk) begin
    bit ovr, rise;
    if (!rstN) begin
      mDr = 0; mOe = 0; mPe = 0; mFe = 0; mBi = 0;
      mThre = 1; mTemt = 1; mHoldPrev = 1;
    end else begin
      ovr  = rxWordLoad && mDr && !rdRxBuf;
      rise = txHoldEmpty && !mHoldPrev;
      mOe  = ovr         ? 1 : (rdLineStat ? 0 : mOe);
      mPe  = rxParityErr ? 1 : (rdLineStat ? 0 : mPe);
      mFe  = rxFrameErr  ? 1 : (rdLineStat ? 0 : mFe);
      mBi  = rxBreak     ? 1 : (rdLineStat ? 0 : mBi);
      mDr  = rxWordLoad  ? 1 : (rdRxBuf ? 0 : mDr);
      mThre = rise ? 1 : ((rdIntId || wrTxHold) ? 0 : mThre);
      mHoldPrev = txHoldEmpty;
      mTemt = txHoldEmpty && txShiftEmpty;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R2 data ready", int'(lineStatus[0]), int'(mDr));
    chk("R3 overrun",    int'(lineStatus[1]), int'(mOe));
    chk("R4 parity",     int'(lineStatus[2]), int'(mPe));
    chk("R4 framing",    int'(lineStatus[3]), int'(mFe));
    chk("R5 break",      int'(lineStatus[4]), int'(mBi));
    chk("R6 hold empty", int'(lineStatus[5]), int'(mThre));
    chk("R7 tx empty",   int'(lineStatus[6]), int'(mTemt));
    chk("R8 spare",      int'(lineStatus[7]), 0);
    chk("R9 rx irq",   int'(irqRxData),   int'(mDr && enRxDataIrq));
    chk("R10 ls irq",  int'(irqLineStat), int'((mOe || mPe || mFe || mBi) && enLineStatIrq));
    chk("R11 tx irq",  int'(irqTxEmpty),  int'(mThre && enTxEmptyIrq));
  endtask

  task automatic clearStrobes();
    rxWordLoad = 0; rxParityErr = 0; rxFrameErr = 0; rxBreak = 0;
    rdLineStat = 0; rdRxBuf = 0; rdIntId = 0; wrTxHold = 0;
  endtask

  // One clock: inputs set before, compare a quarter period after the edge.
  task automatic tick();
    @(posedge clk);
    #5;
    compareAll();
    clearStrobes();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    clearStrobes();
    txHoldEmpty = 1; txShiftEmpty = 1;
    enRxDataIrq = 1; enLineStatIrq = 1; enTxEmptyIrq = 1;
    rstN = 0;
    repeat (3) @(posedge clk);
    #5;
    chk("R1 reset status", int'(lineStatus), 8'h60);
    chk("R1 reset rx irq", int'(irqRxData), 0);
    chk("R1 reset ls irq", int'(irqLineStat), 0);
    rstN = 1;
    tick();

    // R2 / R3: load, second load unread gives overrun, status read clears it
    rxWordLoad = 1; tick();
    rxWordLoad = 1; tick();
    rdLineStat = 1; tick();
    // R3: load with same-cycle buffer read: no overrun
    rxWordLoad = 1; rdRxBuf = 1; tick();
    rdRxBuf = 1; tick();
    // R4 / R5: errors, set wins over same-cycle status read
    rxParityErr = 1; rdLineStat = 1; tick();
    rxFrameErr = 1; tick();
    rxBreak = 1; tick();
    enLineStatIrq = 0; tick();
    enLineStatIrq = 1; rdLineStat = 1; tick();
    // R6 / R7: holding write clears, rise sets, id read clears, collision
    wrTxHold = 1; txHoldEmpty = 0; tick();
    txShiftEmpty = 0; tick();
    txHoldEmpty = 1; tick();
    rdIntId = 1; tick();
    txHoldEmpty = 0; tick();
    txHoldEmpty = 1; rdIntId = 1; tick();
    txShiftEmpty = 1; tick();
    enTxEmptyIrq = 0; enRxDataIrq = 0; tick();

    // Randomized overlap of all strobes and levels
    for (int i = 0; i < 3000; i++) begin
      rxWordLoad   = ($urandom_range(0, 3) == 0);
      rxParityErr  = ($urandom_range(0, 9) == 0);
      rxFrameErr   = ($urandom_range(0, 9) == 0);
      rxBreak      = ($urandom_range(0, 15) == 0);
      rdLineStat   = ($urandom_range(0, 4) == 0);
      rdRxBuf      = ($urandom_range(0, 3) == 0);
      rdIntId      = ($urandom_range(0, 6) == 0);
      wrTxHold     = ($urandom_range(0, 6) == 0);
      if ($urandom_range(0, 4) == 0) txHoldEmpty  = ~txHoldEmpty;
      if ($urandom_range(0, 4) == 0) txShiftEmpty = ~txShiftEmpty;
      enRxDataIrq   = ($urandom_range(0, 3) != 0);
      enLineStatIrq = ($urandom_range(0, 3) != 0);
      enTxEmptyIrq  = ($urandom_range(0, 3) != 0);
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule